// File: doc/BRIEF.md
# Cascaded Serial Switch-Register Loader

This block sits on the host side of a string of serial switch-control devices wired in series. Each device holds a 16-bit shift register. The devices share one serial clock and one latch-enable line. Serial data enters the device nearest the host, and each device's serial output feeds the serial input of the next device. The loader takes one parallel frame that covers every device in the string and a start strobe. It then sends the whole frame as a bit stream on the data line, most significant bit first, while the latch-enable line stays high. This keeps every switch in its old state while the new bits are still moving along the string.

After the last bit, the loader holds latch-enable low for a fixed number of system clock cycles. That one pulse commits the new pattern to all devices at the same moment. Latch-enable then goes high again and stays high until the next frame has been shifted in full. The serial clock comes from the system clock through a divider. The data line changes only on falling serial-clock edges, so each bit is steady when a device samples it on the rising edge. A busy flag covers the whole transfer, a one-cycle done pulse marks its end, and a new start is not accepted while a transfer is running.

The frame is arranged so that the device farthest from the host is filled first. The top 16 bits of the frame therefore end up in the far device, and the bottom 16 bits end up in the device next to the host.

Top module: `chain_loader`

## Requirements
- R1: One transfer produces exactly 16*NUM_DEV rising edges on `sclk_o`. NUM_DEV is the number of devices in the string.
- R2: `sclk_o` rests low whenever no bits are being shifted. While shifting, each high phase of `sclk_o` lasts exactly SCLK_HALF system clock cycles.
- R3: `le_o` is high for the whole shift phase. No rising edge of `sclk_o` occurs while `le_o` is low.
- R4: After the final falling edge of `sclk_o`, `le_o` stays low for exactly LE_LOW_CYC system cycles (at least 1). It then returns high.
- R5: `sdata_o` carries `frame_i[16*NUM_DEV-1]` first and bit 0 last. Once a transfer has begun, `sdata_o` changes only together with a falling edge of `sclk_o`.
- R6: `busy_o` is 1 from the cycle after an accepted start until `le_o` returns high. `done_o` is a single-cycle pulse in the cycle `le_o` returns high, with `busy_o` already 0 in that cycle.
- R7: A start pulse that arrives while `busy_o` is 1 is ignored. `frame_i` is read only in the cycle a start is accepted, so later changes to it do not alter the transfer in progress.
- R8: After a transfer, the device at position k (0 = nearest the host) holds `frame_i[16k+15:16k]`, with `frame_i[16k+15]` as its most significant bit.
- R9: During and after reset, and before any start: `le_o`=1, `sclk_o`=0, `sdata_o`=0, `busy_o`=0, `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe. Accepted only while idle |
| frame_i | input | 16*NUM_DEV | Switch pattern for the whole string. Top segment goes to the far device |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse when the commit pulse ends |
| sclk_o | output | 1 | Serial clock shared by all devices |
| sdata_o | output | 1 | Serial data to the nearest device |
| le_o | output | 1 | Shared latch enable. Low means the new state is committed |

## Verification
The assertions assume that `start_i` and `frame_i` are synchronous to `clk` and that `rst_n` is the only reset. They also assume that nothing outside the block drives the serial lines. The bench changes its inputs only just after a falling system clock edge, so every input is steady at the active edge. It models the device string as a behavioural shift chain clocked by `sclk_o` and latched on the rise of `le_o`. Frames come from a fixed-seed random source, plus all-ones, all-zeros, alternating and single-MSB patterns. On some frames the bench injects a second start with a different frame while the first transfer is still shifting.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int unsigned SEG_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_COMMIT = 2'd2
  } ld_state_e;
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = tick && sclk_q;

  // R2: the serial clock goes to rest when not running
  a_r2_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_q);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] frame_i,
  output logic             sdata_o
);
  logic [WIDTH-1:0] shreg_q, shreg_d;

  always_comb begin
    shreg_d = shreg_q;
    if (load_i)
      shreg_d = frame_i;
    else if (shift_i)
      shreg_d = {shreg_q[WIDTH-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign sdata_o = shreg_q[WIDTH-1];

  // R7: the captured frame is untouched unless loaded or advanced
  a_r7_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(shreg_q));
endmodule

// File: rtl/le_pulser.sv
module le_pulser #(
  parameter int unsigned LOW_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic le_o,
  output logic end_o
);
  localparam int unsigned CW = $clog2(LOW_CYC + 1);
  localparam logic [CW-1:0] FIRST = CW'(LOW_CYC - 1);

  logic          le_q, le_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign end_o = !le_q && (cnt_q == '0);

  always_comb begin
    le_d  = le_q;
    cnt_d = cnt_q;
    if (le_q) begin
      if (fire_i) begin
        le_d  = 1'b0;
        cnt_d = FIRST;
      end
    end else if (cnt_q == '0) begin
      le_d = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      le_q  <= le_d;
      cnt_q <= cnt_d;
    end
  end

  assign le_o = le_q;

  // Checker-only counter of consecutive low cycles
  logic [CW:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_run_q <= '0;
    else if (!le_q) low_run_q <= low_run_q + 1'b1;
    else            low_run_q <= '0;
  end

  // R4: the commit pulse lasts exactly the programmed width
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le_q) |-> (low_run_q == (CW+1)'(LOW_CYC)));
endmodule

// File: rtl/chain_loader.sv
module chain_loader
  import chain_pkg::*;
#(
  parameter int unsigned NUM_DEV    = 3,
  parameter int unsigned SCLK_HALF  = 2,
  parameter int unsigned LE_LOW_CYC = 3,
  localparam int unsigned FRAME_W   = SEG_W * NUM_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               le_o
);
  localparam int unsigned BW = $clog2(FRAME_W + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ld_state_e     state_q, state_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          done_q, done_d;
  logic          load, run, fall, fire, pulse_end;

  assign load = (state_q == ST_IDLE) && start_i;
  assign run  = (state_q == ST_SHIFT);
  assign fire = run && fall && (bit_q == LAST_BIT);

  sclk_divider #(.HALF(SCLK_HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run_i (run),
    .sclk_o(sclk_o),
    .fall_o(fall)
  );

  frame_shifter #(.WIDTH(FRAME_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (load),
    .shift_i(run && fall),
    .frame_i(frame_i),
    .sdata_o(sdata_o)
  );

  le_pulser #(.LOW_CYC(LE_LOW_CYC)) u_le (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .fire_i(fire),
    .le_o  (le_o),
    .end_o (pulse_end)
  );

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SHIFT;
          bit_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (fall) begin
          bit_d = bit_q + 1'b1;
          if (bit_q == LAST_BIT) state_d = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        if (pulse_end) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  // R3: latch enable never drops while bits are moving
  a_r3_le_high_shift: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SHIFT) |-> le_o);
  // R5: data line is steady at every rising serial clock
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sclk_o) |-> $stable(sdata_o));
  // R6: done is a lone pulse with the latch released and busy cleared
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (le_o && !busy_o));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  // R7: once shifting, the transfer is not restarted by another start
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SHIFT) |=> (state_q != ST_IDLE));
endmodule

// File: tb/test_chain_loader.sv
module test_chain_loader;
  localparam int NDEV  = 3;
  localparam int HALF  = 2;
  localparam int LOWC  = 3;
  localparam int FW    = 16 * NDEV;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [FW-1:0] frame_i = '0;
  logic          busy_o, done_o, sclk_o, sdata_o, le_o;

  int n_tests = 0;
  int n_fail  = 0;

  chain_loader #(.NUM_DEV(NDEV), .SCLK_HALF(HALF), .LE_LOW_CYC(LOWC)) i_chain_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .le_o(le_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural device string
  logic [FW-1:0] chain_sr = '0;
  logic [FW-1:0] latched  = '0;
  int rises = 0, le_bad = 0;
  always @(posedge sclk_o) begin
    rises++;
    if (!le_o) le_bad++;
    chain_sr = {chain_sr[FW-2:0], sdata_o};
  end
  always @(posedge le_o) latched = chain_sr;

  // monitors sampled away from the active edge
  int cur_low = 0, last_low = 0, cur_hi = 0, hi_bad = 0, sd_bad = 0;
  int done_seen = 0, done_bad = 0;
  logic prev_busy = 1'b0, prev_sclk = 1'b0, prev_sd = 1'b0;
  always @(negedge clk) begin
    if (!le_o) cur_low++;
    else if (cur_low != 0) begin last_low = cur_low; cur_low = 0; end
    if (sclk_o) cur_hi++;
    else if (cur_hi != 0) begin if (cur_hi != HALF) hi_bad++; cur_hi = 0; end
    if (busy_o && prev_busy && (sdata_o !== prev_sd) && !(prev_sclk && !sclk_o)) sd_bad++;
    if (done_o) done_seen++;
    if (done_o && (busy_o || !le_o)) done_bad++;
    prev_busy = busy_o; prev_sclk = sclk_o; prev_sd = sdata_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] rnd_frame();
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    return v[FW-1:0];
  endfunction

  task automatic run_frame(input logic [FW-1:0] f, input bit poke);
    int n;
    int k;
    @(negedge clk); #1;
    rises = 0; le_bad = 0; hi_bad = 0; sd_bad = 0; done_seen = 0; done_bad = 0; last_low = 0;
    frame_i = f; start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R6 busy after start", 64'(busy_o), 64'd1);
    if (poke) begin
      repeat (20) @(negedge clk);
      #1;
      frame_i = ~f; start_i = 1'b1;   // R7: ignored while busy
      @(negedge clk); #1;
      start_i = 1'b0;
    end
    n = 0;
    while (done_o !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R6 done reached", 64'(n), 64'd0);
    chk(busy_o === 1'b0 && le_o === 1'b1, "R6 state at done", {62'd0, busy_o, le_o}, 64'd1);
    repeat (3) @(negedge clk);
    chk(done_seen == 1 && done_o === 1'b0 && done_bad == 0, "R6 single done pulse",
        64'(done_seen), 64'd1);
    chk(rises == FW, "R1 rising edge count", 64'(rises), 64'(FW));
    chk(le_bad == 0, "R3 no shift while latch low", 64'(le_bad), 64'd0);
    chk(last_low == LOWC, "R4 latch low width", 64'(last_low), 64'(LOWC));
    chk(hi_bad == 0 && sclk_o === 1'b0, "R2 clock phase and rest", 64'(hi_bad), 64'd0);
    chk(sd_bad == 0, "R5 data changes only on falling edge", 64'(sd_bad), 64'd0);
    chk(latched == f, poke ? "R7 frame kept despite restart" : "R5 msb-first frame",
        64'(latched), 64'(f));
    k = $urandom_range(NDEV - 1);
    chk(latched[16*k +: 16] == f[16*k +: 16], "R8 device segment",
        64'(latched[16*k +: 16]), 64'(f[16*k +: 16]));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk({le_o, sclk_o, sdata_o, busy_o, done_o} === 5'b10000, "R9 state in reset",
        64'({le_o, sclk_o, sdata_o, busy_o, done_o}), 64'h10);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({le_o, sclk_o, sdata_o, busy_o, done_o} === 5'b10000, "R9 idle after reset",
        64'({le_o, sclk_o, sdata_o, busy_o, done_o}), 64'h10);

    run_frame({FW{1'b1}}, 1'b0);
    run_frame('0, 1'b0);
    run_frame({(FW/2){2'b10}}, 1'b0);
    run_frame({1'b1, {(FW-1){1'b0}}}, 1'b1);
    for (int i = 0; i < 8; i++) run_frame(rnd_frame(), (i % 2) == 1);

    repeat (10) @(negedge clk);
    chk(sclk_o === 1'b0 && le_o === 1'b1 && busy_o === 1'b0, "R2 rest when idle",
        64'({sclk_o, le_o, busy_o}), 64'h2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule